// File: doc/BRIEF.md
# Configurable Product-Term AND Array

This block is the sum-of-products front end of one logic block. Each of its input signals is presented to the array in true and inverted form. A stored connection mask decides, for every product term, which of those lines take part in a wired-AND. The terms are split into two groups. The logic terms go to the downstream term allocator, and consecutive runs of five belong to one macrocell. Three control terms drive the shared clock, the shared initialization and the shared output enable of the block, and the first two of these can be inverted.

Configuration is loaded one term row per clock through a row-addressed parallel port while a configuration enable is held high. One extra address holds the two inversion bits. While the enable is high, every output is forced low so that downstream logic never sees a half-written array. Once the enable drops, the outputs are purely combinational functions of the inputs.

Top module: `pt_and_array`

## Requirements
- R1: An active-low asynchronous reset clears every connection bit and both inversion bits. After reset, with configuration disabled, all 80 logic terms and all three control outputs read 1.
- R2: Array line 2i carries input i, and line 2i+1 carries its complement. Bit l of a term's row connects line l to that term.
- R3: With configuration disabled, a term outputs the AND of its connected lines. A term with no connected lines outputs 1.
- R4: A term whose row connects both line 2i and line 2i+1 of some input outputs 0 for every input pattern.
- R5: Terms 0 to 79 appear on pt_logic_o bit for bit. Term 5k+m is member m of the cluster of macrocell k. Term 80 drives pt_clk_o, term 81 drives pt_init_o and term 82 drives pt_oe_o.
- R6: Address 83 holds the inversion bits. Data bit 0 inverts pt_clk_o and data bit 1 inverts pt_init_o. pt_oe_o is never inverted.
- R7: A rising clock edge with cfg_en_i and cfg_we_i high and cfg_addr_i in 0..82 loads cfg_data_i into that term's row. The new row takes effect from that edge.
- R8: A write strobe with cfg_en_i low, or with cfg_addr_i above 83, changes no stored bit.
- R9: While cfg_en_i is high, pt_logic_o, pt_clk_o, pt_init_o and pt_oe_o are all 0, whatever the inversion bits are.
- R10: With cfg_en_i low, the outputs follow in_i within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Configuration mode; blanks all outputs |
| cfg_we_i | input | 1 | Row write strobe |
| cfg_addr_i | input | 7 | Term row 0..82, or 83 for the inversion bits |
| cfg_data_i | input | 72 | Row connection mask; bits 1:0 carry the inversion bits at address 83 |
| in_i | input | 36 | Array inputs |
| pt_logic_o | output | 80 | Logic product terms, five per macrocell cluster |
| pt_clk_o | output | 1 | Shared clock term, optionally inverted |
| pt_init_o | output | 1 | Shared initialization term, optionally inverted |
| pt_oe_o | output | 1 | Shared output enable term |

## Verification
The bound checker watches four things on every cycle: output blanking during configuration, row loads landing at their address, the absence of stores while configuration is off or the address is out of range, and the forced values of empty and self-contradicting terms for all 83 rows. The bench's scenarios are the only place where line numbering, cluster and control-term placement, inversion polarity and the same-cycle combinational response to input changes are shown. To do this, it compares every output against a behavioural model across chosen and random input patterns.

// File: rtl/pt_array_pkg.sv
package pt_array_pkg;
  localparam int unsigned NUM_CTRL = 3;
  localparam int unsigned NUM_INV  = 2;

  typedef enum int unsigned {
    CTRL_CLK  = 0,
    CTRL_INIT = 1,
    CTRL_OE   = 2
  } ctrl_term_e;
endpackage

// File: rtl/pt_line_gen.sv
module pt_line_gen #(
  parameter int unsigned NUM_IN   = 36,
  localparam int unsigned NUM_LINE = 2 * NUM_IN
) (
  input  logic [NUM_IN-1:0]   in_i,
  output logic [NUM_LINE-1:0] line_o
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_pair
    assign line_o[2*i]   = in_i[i];
    assign line_o[2*i+1] = ~in_i[i];
  end
endmodule

// File: rtl/pt_cfg_store.sv
module pt_cfg_store #(
  parameter int unsigned NUM_TERM = 83,
  parameter int unsigned NUM_LINE = 72,
  parameter int unsigned NUM_INV  = 2,
  parameter int unsigned ADDR_W   = 7
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               cfg_en_i,
  input  logic                               cfg_we_i,
  input  logic [ADDR_W-1:0]                  cfg_addr_i,
  input  logic [NUM_LINE-1:0]                cfg_data_i,
  output logic [NUM_TERM-1:0][NUM_LINE-1:0]  mask_o,
  output logic [NUM_INV-1:0]                 inv_o
);
  logic wr;
  assign wr = cfg_en_i & cfg_we_i;

  for (genvar r = 0; r < NUM_TERM; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mask_o[r] <= '0;
      else if (wr && cfg_addr_i == ADDR_W'(r))        mask_o[r] <= cfg_data_i;
    end
  end

  // inversion bits live one address past the last term row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      inv_o <= '0;
    else if (wr && cfg_addr_i == ADDR_W'(NUM_TERM))   inv_o <= cfg_data_i[NUM_INV-1:0];
  end
endmodule

// File: rtl/pt_term.sv
module pt_term #(
  parameter int unsigned NUM_LINE = 72
) (
  input  logic [NUM_LINE-1:0] line_i,
  input  logic [NUM_LINE-1:0] mask_i,
  output logic                term_o
);
  // unconnected lines read as 1, so an empty row yields 1
  assign term_o = &(line_i | ~mask_i);
endmodule

// File: rtl/pt_and_array.sv
module pt_and_array
  import pt_array_pkg::*;
#(
  parameter int unsigned NUM_IN    = 36,
  parameter int unsigned NUM_LOGIC = 80,
  parameter int unsigned CLUS_SZ   = 5,
  localparam int unsigned NUM_LINE = 2 * NUM_IN,
  localparam int unsigned NUM_TERM = NUM_LOGIC + NUM_CTRL,
  localparam int unsigned NUM_CLUS = NUM_LOGIC / CLUS_SZ,
  localparam int unsigned ADDR_W   = $clog2(NUM_TERM + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_en_i,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [NUM_LINE-1:0]  cfg_data_i,
  input  logic [NUM_IN-1:0]    in_i,
  output logic [NUM_LOGIC-1:0] pt_logic_o,
  output logic                 pt_clk_o,
  output logic                 pt_init_o,
  output logic                 pt_oe_o
);
  logic [NUM_LINE-1:0]               line;
  logic [NUM_TERM-1:0][NUM_LINE-1:0] mask_q;
  logic [NUM_INV-1:0]                inv_q;
  logic [NUM_TERM-1:0]               term_raw;
  logic [NUM_CTRL-1:0]               ctrl_term;

  pt_line_gen #(.NUM_IN(NUM_IN)) u_lines (
    .in_i   (in_i),
    .line_o (line)
  );

  pt_cfg_store #(
    .NUM_TERM (NUM_TERM),
    .NUM_LINE (NUM_LINE),
    .NUM_INV  (NUM_INV),
    .ADDR_W   (ADDR_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_en_i   (cfg_en_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_data_i (cfg_data_i),
    .mask_o     (mask_q),
    .inv_o      (inv_q)
  );

  // logic terms are grouped per macrocell cluster, control terms follow
  for (genvar k = 0; k < NUM_CLUS; k++) begin : g_clus
    for (genvar m = 0; m < CLUS_SZ; m++) begin : g_mbr
      pt_term #(.NUM_LINE(NUM_LINE)) u_term (
        .line_i (line),
        .mask_i (mask_q[k*CLUS_SZ+m]),
        .term_o (term_raw[k*CLUS_SZ+m])
      );
    end
  end

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
    pt_term #(.NUM_LINE(NUM_LINE)) u_term (
      .line_i (line),
      .mask_i (mask_q[NUM_LOGIC+c]),
      .term_o (term_raw[NUM_LOGIC+c])
    );
    if (c < NUM_INV) begin : g_inv
      assign ctrl_term[c] = ~cfg_en_i & (term_raw[NUM_LOGIC+c] ^ inv_q[c]);
    end else begin : g_plain
      assign ctrl_term[c] = ~cfg_en_i & term_raw[NUM_LOGIC+c];
    end
  end

  assign pt_logic_o = cfg_en_i ? '0 : term_raw[NUM_LOGIC-1:0];
  assign pt_clk_o   = ctrl_term[CTRL_CLK];
  assign pt_init_o  = ctrl_term[CTRL_INIT];
  assign pt_oe_o    = ctrl_term[CTRL_OE];
endmodule

// File: rtl/pt_and_array_chk.sv
module pt_and_array_chk #(
  parameter int unsigned NUM_IN    = 36,
  parameter int unsigned NUM_LOGIC = 80,
  parameter int unsigned NUM_TERM  = 83,
  parameter int unsigned NUM_INV   = 2,
  parameter int unsigned ADDR_W    = 7,
  localparam int unsigned NUM_LINE = 2 * NUM_IN
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               cfg_en_i,
  input logic                               cfg_we_i,
  input logic [ADDR_W-1:0]                  cfg_addr_i,
  input logic [NUM_LINE-1:0]                cfg_data_i,
  input logic [NUM_TERM-1:0][NUM_LINE-1:0]  mask_q,
  input logic [NUM_INV-1:0]                 inv_q,
  input logic [NUM_TERM-1:0]                term_raw,
  input logic [NUM_LOGIC-1:0]               pt_logic_o,
  input logic                               pt_clk_o,
  input logic                               pt_init_o,
  input logic                               pt_oe_o
);
  logic [NUM_TERM-1:0] pair_hit;

  always_comb begin
    pair_hit = '0;
    for (int j = 0; j < NUM_TERM; j++)
      for (int i = 0; i < NUM_IN; i++)
        if (mask_q[j][2*i] && mask_q[j][2*i+1]) pair_hit[j] = 1'b1;
  end

  a_r9_blank_in_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> (pt_logic_o == '0 && !pt_clk_o && !pt_init_o && !pt_oe_o));

  a_r8_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> ($stable(mask_q) && $stable(inv_q)));

  a_r8_bad_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i > ADDR_W'(NUM_TERM)) |=> ($stable(mask_q) && $stable(inv_q)));

  a_r6_inv_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && cfg_we_i && cfg_addr_i == ADDR_W'(NUM_TERM))
      |=> inv_q == $past(cfg_data_i[NUM_INV-1:0]));

  for (genvar j = 0; j < NUM_TERM; j++) begin : g_row_chk
    a_r7_row_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_en_i && cfg_we_i && cfg_addr_i == ADDR_W'(j)) |=> mask_q[j] == $past(cfg_data_i));

    a_r3_empty_is_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q[j] == '0) |-> term_raw[j]);

    a_r4_pair_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pair_hit[j] |-> !term_raw[j]);
  end
endmodule

bind pt_and_array pt_and_array_chk #(
  .NUM_IN    (NUM_IN),
  .NUM_LOGIC (NUM_LOGIC),
  .NUM_TERM  (NUM_TERM),
  .NUM_INV   (pt_array_pkg::NUM_INV),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_en_i   (cfg_en_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_data_i (cfg_data_i),
  .mask_q     (mask_q),
  .inv_q      (inv_q),
  .term_raw   (term_raw),
  .pt_logic_o (pt_logic_o),
  .pt_clk_o   (pt_clk_o),
  .pt_init_o  (pt_init_o),
  .pt_oe_o    (pt_oe_o)
);

// File: tb/pt_and_array_test.sv
module pt_and_array_test;
  localparam int NI = 36;
  localparam int NL = 72;
  localparam int NG = 80;
  localparam int NT = 83;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          cfg_en, cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [NL-1:0] cfg_data;
  logic [NI-1:0] in;
  logic [NG-1:0] pt_logic;
  logic          pt_clk, pt_init, pt_oe;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [NL-1:0] m_mask [NT];
  logic [1:0]    m_inv;

  pt_and_array uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data), .in_i(in),
    .pt_logic_o(pt_logic), .pt_clk_o(pt_clk), .pt_init_o(pt_init), .pt_oe_o(pt_oe)
  );

  always #10 clk = ~clk;

  function automatic logic eval_term(int j);
    logic t = 1'b1;
    for (int i = 0; i < NI; i++) begin
      if (m_mask[j][2*i]   && !in[i]) t = 1'b0;
      if (m_mask[j][2*i+1] &&  in[i]) t = 1'b0;
    end
    return t;
  endfunction

  function automatic logic [NT-1:0] expected();
    logic [NT-1:0] e;
    if (cfg_en) return '0;
    for (int j = 0; j < NT; j++) e[j] = eval_term(j);
    e[NG]   = e[NG]   ^ m_inv[0];
    e[NG+1] = e[NG+1] ^ m_inv[1];
    return e;
  endfunction

  task automatic check(string tag);
    logic [NT-1:0] got, exp;
    got = {pt_oe, pt_init, pt_clk, pt_logic};
    exp = expected();
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(string tag);
    bit en = cfg_en, we = cfg_we;
    logic [AW-1:0] a = cfg_addr;
    logic [NL-1:0] d = cfg_data;
    @(posedge clk);
    if (en && we) begin
      if (a < AW'(NT)) m_mask[a] = d;
      else if (a == AW'(NT)) m_inv = d[1:0];
    end
    #5;
    check(tag);
  endtask

  task automatic wr(int a, logic [NL-1:0] d, string tag);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = d;
    tick(tag);
    cfg_we = 1'b0;
  endtask

  function automatic logic [NL-1:0] ln(int l);
    return NL'(1) << l;
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NT; j++) m_mask[j] = '0;
    m_inv = '0;
    rst_ni = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    in = NI'(36'h5A5A5A5A5);
    #15;
    check("R1 reset");
    rst_ni = 1'b1;
    tick("R1 after reset");
    in = ~in; #1; check("R3 empty rows");

    // configuration session
    cfg_en = 1'b1;
    tick("R9 blank");
    wr(0,  ln(0), "R7");                       // in0 true
    wr(5,  ln(7) | ln(20), "R7");              // !in3 & in10
    wr(12, ln(8) | ln(9), "R4");               // contradiction
    wr(79, {NI{2'b01}}, "R7");                 // all inputs true
    wr(NG,   ln(2), "R5");
    wr(NG+1, ln(4), "R5");
    wr(NG+2, ln(6), "R5");
    wr(NT, NL'(2'b01), "R6");                  // invert clk only
    wr(100, '1, "R8 bad addr");
    cfg_en = 1'b0;

    in = '0;                 tick("R2 zeros");
    in = '1;                 #1; check("R10 all ones");
    in = NI'(36'h400);       #1; check("R2 in10");
    in = NI'(36'h455);       #1; check("R5 ctrl");
    in = NI'(36'h108);       #1; check("R4 pair");

    // write strobe while disabled is dropped
    cfg_we = 1'b1; cfg_addr = AW'(1); cfg_data = ln(0);
    in = '0;
    tick("R8 off write");
    cfg_we = 1'b0;
    #1; check("R8 row1 still empty");

    cfg_en = 1'b1;
    wr(NT, NL'(2'b10), "R6");                  // invert init only
    wr(0, ln(1), "R7 overwrite");
    cfg_en = 1'b0;
    tick("R6 init inverted");
    in = '1; #1; check("R6 polarity");

    cfg_en = 1'b1;
    wr(NT, NL'(2'b11), "R6");
    tick("R9 blank with inversion");
    cfg_en = 1'b0;

    for (int n = 0; n < 40; n++) begin
      in = NI'({$urandom(), $urandom()});
      #1; check("R10 random");
      tick("R3 random");
    end

    cfg_en = 1'b1;
    for (int n = 0; n < 30; n++) begin
      logic [NL-1:0] d = NL'({$urandom(), $urandom(), $urandom()});
      d = d & NL'({$urandom(), $urandom(), $urandom()});
      d = d & NL'({$urandom(), $urandom(), $urandom()});
      wr(int'($urandom_range(0, NT)), d, "R7 random");
    end
    cfg_en = 1'b0;
    for (int n = 0; n < 40; n++) begin
      in = NI'({$urandom(), $urandom()});
      tick("R3 random rows");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule